// File: doc/BRIEF.md
# Banked branch record buffer

This block keeps a short history of taken branches for a performance-monitoring unit. Each accepted branch becomes one record made of a source address, a target address and a 32-bit info word. The newest record is always entry 0. Every new capture moves the older records one place deeper and drops the deepest one. The history is 8, 16, 32 or 64 entries deep, chosen when the block is built.

A branch is recorded only when three things hold. Its class, given by a 4-bit type code on the input, must be enabled. At least one of its two ends must sit at a privilege level that is enabled. Capture must not be paused. When only one end of a branch sits at an enabled level, the block still stores the branch, but it writes zero for the other address and marks the record as partial in the info word. A performance-counter interrupt can set a paused flag, which holds the history intact until software reads it out.

Software reaches the block through a simple register port with a one-bit bank select and a 0..31 slot index. It can read and write the control state, read any entry, and issue an invalidate-all command.

Top module: `branch_record_buf`

## Requirements
- R1: A capture stores the branch in entry 0 and moves entry k to entry k+1 in the same clock edge. After DEPTH further captures a record is no longer visible. DEPTH may be 8, 16, 32 or 64.
- R2: The register address is split as follows. Bits [7:5] select the region: 0 holds the control registers, 1 the source addresses, 2 the target addresses and 3 the info words. For regions 1 to 3, bits [4:0] give the slot. Entry number = 32*bank + slot, where bank is control register FILT bit 12.
- R3: A read returns zero when it addresses an entry number of DEPTH or more, region 0 slots 2 to 31, or regions 4 to 7.
- R4: Info word layout: [1:0] validity, [5:2] type code, [7:6] target level, [8] mispredict, [9] in-transaction, [10] cycle-unknown, [11] zero, [31:12] cycle count. Validity bit 0 means the source is valid and bit 1 means the target is valid. An end whose level is disabled is stored as address zero and its validity bit is 0. The level field holds the target level, or zero when the target is not valid.
- R5: CTRL (region 0, slot 0) bit 0 enables level 0 and bit 1 enables level 1. Levels 2 and 3 are never enabled. A branch with neither end at an enabled level is not recorded.
- R6: The type code decides which enable a branch needs. Codes 0 to 5 need FILT bit [code]. Code 6 (exception) needs CTRL bit 4. Code 7 (exception return) needs CTRL bit 5. Codes 8 to 15 are never recorded.
- R7: CTRL bit 2 set: the cycle field holds the number of clock edges since the previous capture, saturating at 2^20-1. The first capture after reset or invalidate instead gets cycle-unknown set and a cycle count of 0. CTRL bit 2 clear: both fields are 0.
- R8: The mispredict bit equals the input flag when CTRL bit 3 is set. The in-transaction bit equals the input flag. Both are forced to 0 when the source is not valid (target-only record).
- R9: When CTRL bit 6 is set, an interrupt pulse sets the paused flag (FILT bit 8). The next clock edge already sees it. While the flag is set, no branch is recorded. A write to FILT loads the flag from bit 8. When CTRL bit 6 is clear, the interrupt is ignored.
- R10: Writing 1 to bit 0 of CMD (region 0, slot 2) clears every entry to all-zero, validity none. It also makes the next capture cycle-unknown.
- R11: After reset, CTRL, FILT and every entry read zero. CTRL reads back its bits [6:0]. FILT reads back bits [5:0], 8 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brValid | input | 1 | A taken branch is presented this cycle |
| brSrc | input | AW | Branch source address |
| brTgt | input | AW | Branch target address |
| brType | input | 4 | Branch class code |
| brSrcLvl | input | 2 | Privilege level of the source |
| brTgtLvl | input | 2 | Privilege level of the target |
| brMispred | input | 1 | Branch was mispredicted |
| brInTx | input | 1 | Branch was inside a transaction |
| pmuIrq | input | 1 | Performance-counter interrupt pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address (region and slot) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational register read data |

## Verification
A wrong capture decision shows up one clock edge later. The slot-0 record then differs from the expected one, or the branch shows up at slot 1 when it should have been dropped. Unique addresses are used for every branch in the sweep, so a capture that should not have happened can be told apart from one that should. A fault in shifting or banking only shows up when the whole history is read back through both banks, so the full history is compared after the sweeps have filled past the wrap point. A cycle-counter fault shows only in the info word of the next capture, so cycle values are compared on records whose edge spacing is known.

// File: rtl/brb_pkg.sv
`timescale 1ns/1ps
package brb_pkg;
  localparam int REG_W   = 32;
  localparam int CYC_W   = 20;
  localparam int BANK_SZ = 32;

  // control register bit positions
  localparam int C_USER = 0;
  localparam int C_KERN = 1;
  localparam int C_CYC  = 2;
  localparam int C_MISP = 3;
  localparam int C_EXC  = 4;
  localparam int C_ERET = 5;
  localparam int C_FRZ  = 6;
  localparam int CTRL_W = 7;

  // filter register bit positions
  localparam int CLASS_W = 6;
  localparam int F_PAUSE = 8;
  localparam int F_BANK  = 12;

  typedef enum logic [1:0] {
    VAL_NONE = 2'b00,
    VAL_SRC  = 2'b01,
    VAL_TGT  = 2'b10,
    VAL_FULL = 2'b11
  } valid_e;

  typedef struct packed {
    logic [CYC_W-1:0] cycles;
    logic             rsvd;
    logic             cycUnknown;
    logic             inTx;
    logic             mispred;
    logic [1:0]       tgtLvl;
    logic [3:0]       brType;
    valid_e           validity;
  } info_t;

  typedef struct packed {
    logic push;
    logic clearAll;
  } strobe_t;
endpackage

// File: rtl/brb_ctrl.sv
`timescale 1ns/1ps
module brb_ctrl import brb_pkg::*; #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brValid,
  input  logic [AW-1:0] brSrc,
  input  logic [AW-1:0] brTgt,
  input  logic [3:0]    brType,
  input  logic [1:0]    brSrcLvl,
  input  logic [1:0]    brTgtLvl,
  input  logic          brMispred,
  input  logic          brInTx,
  input  logic          pmuIrq,
  input  logic          wrCtrl,
  input  logic          wrFilt,
  input  logic          wrCmd,
  input  logic [12:0]   wrData,
  output strobe_t       strb,
  output logic [AW-1:0] newSrc,
  output logic [AW-1:0] newTgt,
  output info_t         newInfo,
  output logic [REG_W-1:0] ctrlRd,
  output logic [REG_W-1:0] filtRd,
  output logic          bankSel
);
  logic [CTRL_W-1:0]  ctrlQ;
  logic [CLASS_W-1:0] classQ;
  logic               pausedQ;
  logic               bankQ;
  logic               startedQ;
  logic [CYC_W-1:0]   cycCnt;

  logic [7:0] classVec;
  logic       typeOk;
  logic       srcOk;
  logic       tgtOk;
  logic       clearNow;
  logic       pushNow;

  function automatic logic lvlOn(input logic [1:0] lvl, input logic [CTRL_W-1:0] c);
    return ((lvl == 2'd0) && c[C_USER]) || ((lvl == 2'd1) && c[C_KERN]);
  endfunction

  always_comb begin
    // codes 6 and 7 take their enables from the control register
    classVec = {ctrlQ[C_ERET], ctrlQ[C_EXC], classQ};
    typeOk   = !brType[3] && classVec[brType[2:0]];
    srcOk    = lvlOn(brSrcLvl, ctrlQ);
    tgtOk    = lvlOn(brTgtLvl, ctrlQ);
    clearNow = wrCmd && wrData[0];
    pushNow  = brValid && typeOk && (srcOk || tgtOk) && !pausedQ && !clearNow;

    strb.push     = pushNow;
    strb.clearAll = clearNow;

    newSrc = srcOk ? brSrc : '0;
    newTgt = tgtOk ? brTgt : '0;

    newInfo            = '0;
    newInfo.validity   = valid_e'({tgtOk, srcOk});
    newInfo.brType     = brType;
    newInfo.tgtLvl     = tgtOk ? brTgtLvl : 2'd0;
    newInfo.mispred    = srcOk && brMispred && ctrlQ[C_MISP];
    newInfo.inTx       = srcOk && brInTx;
    newInfo.cycUnknown = ctrlQ[C_CYC] && !startedQ;
    newInfo.cycles     = (ctrlQ[C_CYC] && startedQ) ? cycCnt : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ    <= '0;
      classQ   <= '0;
      pausedQ  <= 1'b0;
      bankQ    <= 1'b0;
      startedQ <= 1'b0;
      cycCnt   <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= wrData[CTRL_W-1:0];
      if (wrFilt) begin
        classQ <= wrData[CLASS_W-1:0];
        bankQ  <= wrData[F_BANK];
      end
      if (pmuIrq && ctrlQ[C_FRZ]) pausedQ <= 1'b1;
      else if (wrFilt)            pausedQ <= wrData[F_PAUSE];
      if (clearNow)     startedQ <= 1'b0;
      else if (pushNow) startedQ <= 1'b1;
      if (pushNow)               cycCnt <= CYC_W'(1);
      else if (cycCnt != '1)     cycCnt <= cycCnt + 1'b1;
    end
  end

  assign ctrlRd  = REG_W'(ctrlQ);
  assign filtRd  = {19'b0, bankQ, 3'b0, pausedQ, 2'b0, classQ};
  assign bankSel = bankQ;

  assert_freeze_sets_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pmuIrq && ctrlQ[C_FRZ]) |=> pausedQ);

  assert_pause_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pausedQ) |-> ($past(pmuIrq && ctrlQ[C_FRZ]) || $past(wrFilt && wrData[F_PAUSE])));

  assert_push_needs_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.push |-> (ctrlQ[C_USER] || ctrlQ[C_KERN]));

  assert_paused_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pausedQ && !wrFilt) |=> pausedQ);
endmodule

// File: rtl/brb_store.sv
`timescale 1ns/1ps
module brb_store import brb_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       strb,
  input  logic [AW-1:0] newSrc,
  input  logic [AW-1:0] newTgt,
  input  info_t         newInfo,
  input  logic [5:0]    rdIdx,
  output logic [AW-1:0] rdSrc,
  output logic [AW-1:0] rdTgt,
  output info_t         rdInfo
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [AW-1:0] srcQ [DEPTH];
  logic [AW-1:0] tgtQ [DEPTH];
  info_t         infQ [DEPTH];
  logic [AW-1:0] srcIn [DEPTH];
  logic [AW-1:0] tgtIn [DEPTH];
  info_t         infIn [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_head
      assign srcIn[i] = newSrc;
      assign tgtIn[i] = newTgt;
      assign infIn[i] = newInfo;
    end else begin : g_tail
      assign srcIn[i] = srcQ[i-1];
      assign tgtIn[i] = tgtQ[i-1];
      assign infIn[i] = infQ[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        srcQ[i] <= '0;
        tgtQ[i] <= '0;
        infQ[i] <= '0;
      end else if (strb.clearAll) begin
        srcQ[i] <= '0;
        tgtQ[i] <= '0;
        infQ[i] <= '0;
      end else if (strb.push) begin
        srcQ[i] <= srcIn[i];
        tgtQ[i] <= tgtIn[i];
        infQ[i] <= infIn[i];
      end
    end
  end

  always_comb begin
    rdSrc  = '0;
    rdTgt  = '0;
    rdInfo = '0;
    if ({1'b0, rdIdx} < 7'(DEPTH)) begin
      rdSrc  = srcQ[rdIdx[IDX_W-1:0]];
      rdTgt  = tgtQ[rdIdx[IDX_W-1:0]];
      rdInfo = infQ[rdIdx[IDX_W-1:0]];
    end
  end

  assert_push_lands_newest_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.push && !strb.clearAll) |=> (infQ[0] == $past(newInfo) && srcQ[0] == $past(newSrc)));

  assert_push_shifts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.push && !strb.clearAll) |=> (infQ[1] == $past(infQ[0]) && tgtQ[1] == $past(tgtQ[0])));

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearAll |=> (infQ[0].validity == VAL_NONE && infQ[DEPTH-1].validity == VAL_NONE));

  assert_tgt_only_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (infQ[0].validity == VAL_TGT) |-> (srcQ[0] == '0));

  assert_src_only_zero_tgt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (infQ[0].validity == VAL_SRC) |-> (tgtQ[0] == '0));
endmodule

// File: rtl/branch_record_buf.sv
`timescale 1ns/1ps
module branch_record_buf import brb_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brValid,
  input  logic [AW-1:0] brSrc,
  input  logic [AW-1:0] brTgt,
  input  logic [3:0]    brType,
  input  logic [1:0]    brSrcLvl,
  input  logic [1:0]    brTgtLvl,
  input  logic          brMispred,
  input  logic          brInTx,
  input  logic          pmuIrq,
  input  logic          regWrEn,
  input  logic [7:0]    regAddr,
  input  logic [31:0]   regWrData,
  output logic [31:0]   regRdData
);
  logic [2:0] region;
  logic [4:0] slot;
  logic       wrCtrl, wrFilt, wrCmd;
  strobe_t    strb;
  logic [AW-1:0] newSrc, newTgt, rdSrc, rdTgt;
  info_t      newInfo, rdInfo;
  logic [REG_W-1:0] ctrlRd, filtRd;
  logic       bankSel;

  assign region = regAddr[7:5];
  assign slot   = regAddr[4:0];
  assign wrCtrl = regWrEn && (region == 3'd0) && (slot == 5'd0);
  assign wrFilt = regWrEn && (region == 3'd0) && (slot == 5'd1);
  assign wrCmd  = regWrEn && (region == 3'd0) && (slot == 5'd2);

  brb_ctrl #(.AW(AW)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .brValid(brValid), .brSrc(brSrc), .brTgt(brTgt), .brType(brType),
    .brSrcLvl(brSrcLvl), .brTgtLvl(brTgtLvl),
    .brMispred(brMispred), .brInTx(brInTx), .pmuIrq(pmuIrq),
    .wrCtrl(wrCtrl), .wrFilt(wrFilt), .wrCmd(wrCmd), .wrData(regWrData[12:0]),
    .strb(strb), .newSrc(newSrc), .newTgt(newTgt), .newInfo(newInfo),
    .ctrlRd(ctrlRd), .filtRd(filtRd), .bankSel(bankSel)
  );

  brb_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .newSrc(newSrc), .newTgt(newTgt), .newInfo(newInfo),
    .rdIdx({bankSel, slot}),
    .rdSrc(rdSrc), .rdTgt(rdTgt), .rdInfo(rdInfo)
  );

  always_comb begin
    case (region)
      3'd0: begin
        if (slot == 5'd0)      regRdData = ctrlRd;
        else if (slot == 5'd1) regRdData = filtRd;
        else                   regRdData = '0;
      end
      3'd1:    regRdData = 32'(rdSrc);
      3'd2:    regRdData = 32'(rdTgt);
      3'd3:    regRdData = rdInfo;
      default: regRdData = '0;
    endcase
  end

  assert_beyond_depth_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((region == 3'd1 || region == 3'd2 || region == 3'd3) &&
     ({1'b0, bankSel, slot} >= 7'(DEPTH))) |-> (regRdData == '0));

  assert_unused_region_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    region[2] |-> (regRdData == '0));
endmodule

// File: tb/branch_record_buf_tb.sv
`timescale 1ns/1ps
module branch_record_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        brValid = 1'b0;
  logic [31:0] brSrc = '0, brTgt = '0;
  logic [3:0]  brType = '0;
  logic [1:0]  brSrcLvl = '0, brTgtLvl = '0;
  logic        brMispred = 1'b0, brInTx = 1'b0, pmuIrq = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] rdBig, rdSmall;

  int total = 0;
  int bad = 0;
  int benchCyc = 0;

  // bench model of the expected history and control state
  logic [31:0] mSrc [64];
  logic [31:0] mTgt [64];
  logic [31:0] mInf [64];
  logic [6:0]  mCtrl = '0;
  logic [5:0]  mFilt = '0;
  logic        mPaused = 1'b0;
  logic        mBank = 1'b0;
  logic        mStarted = 1'b0;
  int          mLast = 0;
  int          seq = 0;

  always #2 clk = ~clk;

  branch_record_buf #(.DEPTH(64), .AW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .brValid(brValid), .brSrc(brSrc), .brTgt(brTgt),
    .brType(brType), .brSrcLvl(brSrcLvl), .brTgtLvl(brTgtLvl),
    .brMispred(brMispred), .brInTx(brInTx), .pmuIrq(pmuIrq),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(rdBig)
  );

  branch_record_buf #(.DEPTH(8), .AW(32)) dutSmall_i (
    .clk(clk), .rst_n(rst_n), .brValid(brValid), .brSrc(brSrc), .brTgt(brTgt),
    .brType(brType), .brSrcLvl(brSrcLvl), .brTgtLvl(brTgtLvl),
    .brMispred(brMispred), .brInTx(brInTx), .pmuIrq(pmuIrq),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(rdSmall)
  );

  always @(posedge clk) begin
    benchCyc <= benchCyc + 1;
    if (benchCyc == 180000) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish got=%0d exp=<180000", benchCyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  function automatic logic lvlOn(input int l);
    return (l == 0 && mCtrl[0]) || (l == 1 && mCtrl[1]);
  endfunction

  task automatic clearModel();
    for (int i = 0; i < 64; i++) begin mSrc[i] = '0; mTgt[i] = '0; mInf[i] = '0; end
    mStarted = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 8'h00) mCtrl = d[6:0];
    if (a == 8'h01) begin mFilt = d[5:0]; mPaused = d[8]; mBank = d[12]; end
    if (a == 8'h02 && d[0]) clearModel();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] big, output logic [31:0] sml);
    @(negedge clk);
    regAddr = a;
    #1;
    big = rdBig;
    sml = rdSmall;
  endtask

  task automatic irq();
    @(negedge clk);
    pmuIrq = 1'b1;
    @(negedge clk);
    pmuIrq = 1'b0;
    if (mCtrl[6]) mPaused = 1'b1;
  endtask

  task automatic doBr(input logic [31:0] s, input logic [31:0] t, input int ty,
                      input int sl, input int tl, input logic m, input logic x);
    logic typeOk, sOk, tOk, unk;
    logic [19:0] cyc;
    int e;
    @(negedge clk);
    brValid = 1'b1; brSrc = s; brTgt = t; brType = 4'(ty);
    brSrcLvl = 2'(sl); brTgtLvl = 2'(tl); brMispred = m; brInTx = x;
    @(negedge clk);
    e = benchCyc;
    brValid = 1'b0;
    typeOk = (ty < 6) ? mFilt[ty] : (ty == 6) ? mCtrl[4] : (ty == 7) ? mCtrl[5] : 1'b0;
    sOk = lvlOn(sl);
    tOk = lvlOn(tl);
    if (typeOk && (sOk || tOk) && !mPaused) begin
      unk = 1'b0; cyc = '0;
      if (mCtrl[2]) begin
        unk = !mStarted;
        if (mStarted) cyc = ((e - mLast) > 1048575) ? 20'hFFFFF : 20'(e - mLast);
      end
      for (int i = 63; i > 0; i--) begin
        mSrc[i] = mSrc[i-1]; mTgt[i] = mTgt[i-1]; mInf[i] = mInf[i-1];
      end
      mSrc[0] = sOk ? s : '0;
      mTgt[0] = tOk ? t : '0;
      mInf[0] = {cyc, 1'b0, unk, sOk & x, sOk & m & mCtrl[3],
                 tOk ? 2'(tl) : 2'b0, 4'(ty), tOk, sOk};
      mStarted = 1'b1;
      mLast = e;
    end
  endtask

  task automatic chkHead(input string req);
    logic [31:0] b, s;
    rd(8'h20, b, s); chk(req, "entry0 src", b, mSrc[0]); chk(req, "small entry0 src", s, mSrc[0]);
    rd(8'h40, b, s); chk(req, "entry0 tgt", b, mTgt[0]);
    rd(8'h60, b, s); chk(req, "entry0 info", b, mInf[0]); chk(req, "small entry0 info", s, mInf[0]);
    rd(8'h61, b, s); chk("R1", "entry1 info", b, mInf[1]);
  endtask

  task automatic chkAll(input string req);
    logic [31:0] b, s;
    for (int bank = 0; bank < 2; bank++) begin
      wr(8'h01, 32'(mFilt) | (32'(bank) << 12) | (32'(mPaused) << 8));
      for (int ix = 0; ix < 32; ix++) begin
        int n;
        n = bank * 32 + ix;
        rd({3'd1, 5'(ix)}, b, s);
        chk(bank ? "R2" : req, "src", b, mSrc[n]);
        chk((n >= 8) ? "R3" : req, "small src", s, (n < 8) ? mSrc[n] : 32'h0);
        rd({3'd2, 5'(ix)}, b, s);
        chk(bank ? "R2" : req, "tgt", b, mTgt[n]);
        chk((n >= 8) ? "R3" : req, "small tgt", s, (n < 8) ? mTgt[n] : 32'h0);
        rd({3'd3, 5'(ix)}, b, s);
        chk(bank ? "R2" : req, "info", b, mInf[n]);
        chk((n >= 8) ? "R3" : req, "small info", s, (n < 8) ? mInf[n] : 32'h0);
      end
    end
    wr(8'h01, 32'(mFilt) | (32'(mPaused) << 8));
  endtask

  initial begin
    logic [31:0] b, s;
    logic [6:0] ctrlSet [4];
    logic [5:0] filtSet [2];
    ctrlSet[0] = 7'h3F; ctrlSet[1] = 7'h31; ctrlSet[2] = 7'h2E; ctrlSet[3] = 7'h1C;
    filtSet[0] = 6'h3F; filtSet[1] = 6'h15;
    clearModel();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(8'h00, b, s); chk("R11", "ctrl after reset", b, 32'h0);
    rd(8'h01, b, s); chk("R11", "filt after reset", b, 32'h0);
    rd(8'h60, b, s); chk("R11", "entry0 info after reset", b, 32'h0);

    wr(8'h00, 32'h3F);
    wr(8'h01, 32'h3F);
    rd(8'h00, b, s); chk("R11", "ctrl readback", b, 32'h3F);
    rd(8'h01, b, s); chk("R11", "filt readback", b, 32'h3F);

    // R7 cycle counting
    doBr(32'hA000_0010, 32'hB000_0020, 0, 0, 0, 1'b1, 1'b0);
    chkHead("R7");
    repeat (5) @(negedge clk);
    doBr(32'hA000_0030, 32'hB000_0040, 5, 1, 1, 1'b0, 1'b1);
    chkHead("R7");
    wr(8'h00, 32'h3B);
    doBr(32'hA000_0050, 32'hB000_0060, 1, 0, 1, 1'b1, 1'b1);
    chkHead("R7");

    // R8 mispredict enable off, and target-only forcing
    wr(8'h00, 32'h37);
    doBr(32'hA000_0070, 32'hB000_0080, 2, 0, 0, 1'b1, 1'b1);
    chkHead("R8");
    wr(8'h00, 32'h3D);
    doBr(32'hA000_0090, 32'hB000_00A0, 3, 1, 0, 1'b1, 1'b1);
    chkHead("R8");

    // R5 no level enabled: nothing recorded
    wr(8'h00, 32'h3C);
    doBr(32'hA000_00B0, 32'hB000_00C0, 4, 0, 1, 1'b0, 1'b0);
    chkHead("R5");

    // sweep every type code and level pair under several enable sets
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 2; f++) begin
        wr(8'h00, 32'(ctrlSet[c]));
        wr(8'h01, 32'(filtSet[f]));
        for (int ty = 0; ty < 16; ty++) begin
          for (int sl = 0; sl < 4; sl++) begin
            for (int tl = 0; tl < 4; tl++) begin
              seq++;
              doBr(32'h1000_0000 | 32'(seq), 32'h2000_0000 | (32'(seq) << 1),
                   ty, sl, tl, seq[0], seq[1]);
              chkHead((ty >= 6) ? "R6" : "R4");
            end
          end
        end
      end
    end
    chkAll("R1");

    // R9 freeze on interrupt
    wr(8'h00, 32'h7F);
    wr(8'h01, 32'h3F);
    irq();
    rd(8'h01, b, s); chk("R9", "paused flag after irq", b, 32'h13F);
    doBr(32'hC000_0001, 32'hD000_0001, 0, 0, 0, 1'b0, 1'b0);
    chkHead("R9");
    wr(8'h01, 32'h3F);
    doBr(32'hC000_0002, 32'hD000_0002, 0, 0, 0, 1'b0, 1'b0);
    chkHead("R9");
    wr(8'h00, 32'h3F);
    irq();
    rd(8'h01, b, s); chk("R9", "irq ignored without freeze", b, 32'h3F);
    doBr(32'hC000_0003, 32'hD000_0003, 1, 1, 1, 1'b1, 1'b0);
    chkHead("R9");

    // R10 invalidate all
    wr(8'h02, 32'h1);
    chkAll("R10");
    doBr(32'hC000_0004, 32'hD000_0004, 5, 0, 1, 1'b1, 1'b1);
    chkHead("R10");
    rd(8'h60, b, s); chk("R10", "cycle-unknown after invalidate", 32'(b[10]), 32'h1);

    // R3 unused addresses
    rd(8'h03, b, s); chk("R3", "control slot 3", b, 32'h0);
    rd(8'h02, b, s); chk("R3", "command slot reads zero", b, 32'h0);
    rd(8'h80, b, s); chk("R3", "region 4", b, 32'h0);
    rd(8'hE5, b, s); chk("R3", "region 7", b, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule